// File: doc/BRIEF.md
# Range-Matched Recency Translation Buffer

This block is a small, fully associative store of address translations. Each slot holds a virtual start address, a region size given as a power-of-two exponent, a physical base and a global flag. A region may be anywhere from one byte up to half of the virtual space. The slots are kept in a strict most-recent-first order. Slots that hold no translation form a free pool, and a new translation takes a slot from that pool before anything is evicted.

The lookup side is purely combinational. It presents a virtual address and returns hit, the translated physical address, the matching slot's size exponent and its global flag. An optional touch input promotes the matching slot to most recent on the next clock edge. The command side carries one operation per cycle: fill a new translation, flush everything, flush only the non-global slots, or drop the one translation that covers an address. Commands and promotions take effect on the rising clock edge. A lookup in the same cycle therefore still sees the contents and order from before that edge.

Top module: `xlat_rtlb`

## Requirements
- R1: After reset every slot is free and every lookup misses.
- R2: A slot matches address A when start <= A and A < start + 2^size_exp, compared without wraparound, so the first and last byte of a region hit and the bytes just outside it miss.
- R3: On a hit, lk_pa is the slot's physical base ORed with A modulo 2^size_exp, and lk_size and lk_global return the slot's fields. On a miss, all three are zero.
- R4: A fill takes a free slot when one exists, so ENTRIES fills into an empty buffer leave all of them resident.
- R5: A fill into a full buffer evicts the least recently used slot.
- R6: A filled translation becomes the most recently used and hits from the next cycle on.
- R7: A lookup with lk_touch set that hits, in a cycle with no command, makes that slot most recent. A lookup with lk_touch clear leaves the order unchanged.
- R8: When several slots match, the most recently used one supplies the result.
- R9: Command code 2 (flush all) frees every slot.
- R10: Command code 3 (flush local) frees exactly the slots whose global flag is clear. Global slots stay resident.
- R11: Command code 4 (drop) frees only the most recent slot covering cmd_va and does not reorder the others.
- R12: Command codes are 0 none, 1 fill, 2 flush all, 3 flush local and 4 drop. Codes 5 to 7 act as none. A command takes effect at the clock edge, so a lookup in the same cycle sees the earlier state. Any command from 1 to 4 suppresses a touch in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_va | input | VA_W | Lookup virtual address |
| lk_touch | input | 1 | Promote the hit slot to most recent |
| lk_hit | output | 1 | Lookup matched a resident slot |
| lk_pa | output | PA_W | Translated physical address |
| lk_size | output | LG_W | Size exponent of the matching slot |
| lk_global | output | 1 | Global flag of the matching slot |
| cmd_op | input | 3 | Command code (see R12) |
| cmd_va | input | VA_W | Fill start address, or drop address |
| cmd_size | input | LG_W | Fill size exponent |
| cmd_pa | input | PA_W | Fill physical base |
| cmd_global | input | 1 | Fill global flag |

## Verification
The bench builds the block with four slots, a 16-bit virtual space and a 20-bit physical space. With only four slots, the buffer fills within a few random commands, so evictions, wholesale flushes and overlaps among aligned regions of 1 to 64 bytes all happen constantly. The reference is an ordered list, most recent first, which differs from the age counters in the design. The narrow spaces keep lookups landing on resident regions and on their edges often enough that range boundaries and overlap priority are exercised beyond the directed cases.

// File: rtl/xlat_rtlb_pkg.sv
package xlat_rtlb_pkg;
   typedef enum logic [2:0] {
      OP_NONE        = 3'd0,
      OP_FILL        = 3'd1,
      OP_FLUSH_ALL   = 3'd2,
      OP_FLUSH_LOCAL = 3'd3,
      OP_DROP        = 3'd4
   } rtlb_op_e;
endpackage

// File: rtl/xlat_rtlb_match.sv
// Range comparator for one slot: start <= va < start + 2^lg, no wraparound.
module xlat_rtlb_match #(
   parameter int VA_W = 32,
   parameter int LG_W = 5
) (
   input  logic            vld,
   input  logic [VA_W-1:0] base,
   input  logic [LG_W-1:0] lg,
   input  logic [VA_W-1:0] va,
   output logic            hit
);
   logic [VA_W:0] limit;

   always_comb begin
      limit = {1'b0, base} + ((VA_W+1)'(1) << lg);
      hit   = vld && (va >= base) && ({1'b0, va} < limit);
   end
endmodule

// File: rtl/xlat_rtlb_pick.sv
// Among the matching slots, selects the one with the smallest age.
module xlat_rtlb_pick #(
   parameter int ENTRIES = 8,
   parameter int AGE_W   = 3
) (
   input  logic [ENTRIES-1:0]            hits,
   input  logic [ENTRIES-1:0][AGE_W-1:0] ages,
   output logic                          found,
   output logic [AGE_W-1:0]              idx
);
   logic [AGE_W-1:0] best;

   always_comb begin
      found = 1'b0;
      idx   = '0;
      best  = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hits[i] && (!found || ages[i] < best)) begin
            found = 1'b1;
            idx   = AGE_W'(i);
            best  = ages[i];
         end
      end
   end
endmodule

// File: rtl/xlat_rtlb_age.sv
// Valid bits and age counters. Age 0 is most recent, and the ages of the
// resident slots are always 0..count-1.
module xlat_rtlb_age #(
   parameter int ENTRIES = 8,
   parameter int AGE_W   = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          mark_en,
   input  logic [AGE_W-1:0]              mark_idx,
   input  logic [ENTRIES-1:0]            free_vec,
   output logic [ENTRIES-1:0]            valid_q,
   output logic [ENTRIES-1:0][AGE_W-1:0] ages_q,
   output logic [AGE_W-1:0]              victim
);
   logic [ENTRIES-1:0]            valid_d;
   logic [ENTRIES-1:0][AGE_W-1:0] ages_d;
   logic [ENTRIES-1:0][AGE_W-1:0] dec;

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         dec[i] = '0;
         for (int j = 0; j < ENTRIES; j++) begin
            if (free_vec[j] && valid_q[j] && (ages_q[j] < ages_q[i]))
               dec[i] = dec[i] + AGE_W'(1);
         end
      end
      valid_d = valid_q;
      ages_d  = ages_q;
      if (mark_en) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (AGE_W'(i) == mark_idx) begin
               valid_d[i] = 1'b1;
               ages_d[i]  = '0;
            end else if (valid_q[i] &&
                         (!valid_q[mark_idx] || ages_q[i] < ages_q[mark_idx])) begin
               ages_d[i] = ages_q[i] + AGE_W'(1);
            end
         end
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (free_vec[i]) valid_d[i] = 1'b0;
            else             ages_d[i]  = ages_q[i] - dec[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         ages_q  <= '0;
      end else begin
         valid_q <= valid_d;
         ages_q  <= ages_d;
      end
   end

   // Lowest free slot first; when none is free, the oldest resident slot.
   always_comb begin
      victim = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (valid_q[i] && ages_q[i] == AGE_W'(ENTRIES-1)) victim = AGE_W'(i);
      end
      for (int i = ENTRIES-1; i >= 0; i--) begin
         if (!valid_q[i]) victim = AGE_W'(i);
      end
   end
endmodule

// File: rtl/xlat_rtlb.sv
module xlat_rtlb
   import xlat_rtlb_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VA_W    = 32,
   parameter int PA_W    = 32,
   parameter int LG_W    = $clog2(VA_W)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [VA_W-1:0] lk_va,
   input  logic            lk_touch,
   output logic            lk_hit,
   output logic [PA_W-1:0] lk_pa,
   output logic [LG_W-1:0] lk_size,
   output logic            lk_global,
   input  logic [2:0]      cmd_op,
   input  logic [VA_W-1:0] cmd_va,
   input  logic [LG_W-1:0] cmd_size,
   input  logic [PA_W-1:0] cmd_pa,
   input  logic            cmd_global
);
   localparam int AGE_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2 || ENTRIES > 64) begin : g_bad_entries
      $error("xlat_rtlb: ENTRIES must lie in 2..64");
   end
   if (VA_W < 2 || PA_W < 2) begin : g_bad_width
      $error("xlat_rtlb: address widths must be at least 2");
   end
   if ((1 << LG_W) < VA_W) begin : g_bad_lg
      $error("xlat_rtlb: LG_W too narrow for VA_W");
   end

   logic [VA_W-1:0] base_q [ENTRIES];
   logic [LG_W-1:0] lg_q   [ENTRIES];
   logic [PA_W-1:0] pa_q   [ENTRIES];
   logic [ENTRIES-1:0] glob_q;

   logic [ENTRIES-1:0]            ent_valid;
   logic [ENTRIES-1:0][AGE_W-1:0] ent_age;
   logic [ENTRIES-1:0]            lk_hits, cmd_hits;
   logic                          lk_found, cmd_found;
   logic [AGE_W-1:0]              lk_idx, cmd_idx, victim;
   logic                          mark_en;
   logic [AGE_W-1:0]              mark_idx;
   logic [ENTRIES-1:0]            free_vec;
   logic [VA_W-1:0]               off_mask;
   rtlb_op_e                      op;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      xlat_rtlb_match #(.VA_W(VA_W), .LG_W(LG_W)) u_lk_cmp (
         .vld(ent_valid[g]), .base(base_q[g]), .lg(lg_q[g]),
         .va(lk_va), .hit(lk_hits[g]));
      xlat_rtlb_match #(.VA_W(VA_W), .LG_W(LG_W)) u_cmd_cmp (
         .vld(ent_valid[g]), .base(base_q[g]), .lg(lg_q[g]),
         .va(cmd_va), .hit(cmd_hits[g]));
   end

   xlat_rtlb_pick #(.ENTRIES(ENTRIES), .AGE_W(AGE_W)) u_lk_pick (
      .hits(lk_hits), .ages(ent_age), .found(lk_found), .idx(lk_idx));
   xlat_rtlb_pick #(.ENTRIES(ENTRIES), .AGE_W(AGE_W)) u_cmd_pick (
      .hits(cmd_hits), .ages(ent_age), .found(cmd_found), .idx(cmd_idx));

   xlat_rtlb_age #(.ENTRIES(ENTRIES), .AGE_W(AGE_W)) u_age (
      .clk(clk), .rst_n(rst_n), .mark_en(mark_en), .mark_idx(mark_idx),
      .free_vec(free_vec), .valid_q(ent_valid), .ages_q(ent_age),
      .victim(victim));

   always_comb begin
      op       = rtlb_op_e'(cmd_op);
      mark_en  = 1'b0;
      mark_idx = lk_idx;
      free_vec = '0;
      case (op)
         OP_FILL: begin
            mark_en  = 1'b1;
            mark_idx = victim;
         end
         OP_FLUSH_ALL:   free_vec = ent_valid;
         OP_FLUSH_LOCAL: free_vec = ent_valid & ~glob_q;
         OP_DROP: begin
            for (int i = 0; i < ENTRIES; i++)
               free_vec[i] = cmd_found && (AGE_W'(i) == cmd_idx);
         end
         default: mark_en = lk_touch && lk_found;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         glob_q <= '0;
      end else if (op == OP_FILL) begin
         base_q[victim] <= cmd_va;
         lg_q[victim]   <= cmd_size;
         pa_q[victim]   <= cmd_pa;
         glob_q[victim] <= cmd_global;
      end
   end

   always_comb begin
      off_mask  = ~({VA_W{1'b1}} << lg_q[lk_idx]);
      lk_hit    = lk_found;
      lk_pa     = '0;
      lk_size   = '0;
      lk_global = 1'b0;
      if (lk_found) begin
         lk_pa     = pa_q[lk_idx] | PA_W'(lk_va & off_mask);
         lk_size   = lg_q[lk_idx];
         lk_global = glob_q[lk_idx];
      end
   end
endmodule

// File: rtl/xlat_rtlb_chk.sv
module xlat_rtlb_chk #(
   parameter int ENTRIES = 8,
   parameter int AGE_W   = 3,
   parameter int VA_W    = 32
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [2:0]                    cmd_op,
   input logic [VA_W-1:0]               cmd_va,
   input logic [VA_W-1:0]               lk_va,
   input logic                          lk_hit,
   input logic [ENTRIES-1:0]            valid,
   input logic [ENTRIES-1:0][AGE_W-1:0] ages,
   input logic [ENTRIES-1:0]            glob
);
   logic [ENTRIES-1:0] young_v, old_v;

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         young_v[i] = valid[i] && (ages[i] == '0);
         old_v[i]   = valid[i] && (ages[i] == AGE_W'(ENTRIES-1));
      end
   end

   AST_EMPTY_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
      (valid == '0) |-> !lk_hit); // R1
   AST_ONE_LRU_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (&valid) |-> ($countones(old_v) == 1)); // R5
   AST_FILL_HITS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 3'd1) |=> ((lk_va != $past(cmd_va)) || lk_hit)); // R6
   AST_SINGLE_MRU: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(young_v)); // R7
   AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 3'd2) |=> (valid == '0)); // R9
   AST_FLUSH_LOCAL_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 3'd3) |=> ((valid & ~glob) == '0)); // R10
endmodule

bind xlat_rtlb xlat_rtlb_chk #(.ENTRIES(ENTRIES), .AGE_W(AGE_W), .VA_W(VA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_va(cmd_va), .lk_va(lk_va),
   .lk_hit(lk_hit), .valid(ent_valid), .ages(ent_age), .glob(glob_q));

// File: tb/test_xlat_rtlb.sv
`timescale 1ns/1ps
module test_xlat_rtlb;
   localparam int N    = 4;
   localparam int VA_W = 16;
   localparam int PA_W = 20;
   localparam int LG_W = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [VA_W-1:0] lk_va = '0;
   logic            lk_touch = 1'b0;
   logic            lk_hit;
   logic [PA_W-1:0] lk_pa;
   logic [LG_W-1:0] lk_size;
   logic            lk_global;
   logic [2:0]      cmd_op = '0;
   logic [VA_W-1:0] cmd_va = '0;
   logic [LG_W-1:0] cmd_size = '0;
   logic [PA_W-1:0] cmd_pa = '0;
   logic            cmd_global = 1'b0;

   int vectors = 0;
   int miscompares = 0;

   // Reference: resident translations as a list, most recent at index 0.
   logic [VA_W-1:0] m_base [N];
   logic [LG_W-1:0] m_lg   [N];
   logic [PA_W-1:0] m_pa   [N];
   logic            m_glob [N];
   int              m_cnt = 0;

   always #2.5 clk = ~clk;

   xlat_rtlb #(.ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W), .LG_W(LG_W)) i_xlat_rtlb (
      .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_touch(lk_touch),
      .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_size(lk_size), .lk_global(lk_global),
      .cmd_op(cmd_op), .cmd_va(cmd_va), .cmd_size(cmd_size), .cmd_pa(cmd_pa),
      .cmd_global(cmd_global));

   function automatic int m_find(logic [VA_W-1:0] va);
      for (int k = 0; k < m_cnt; k++) begin
         if (int'(va) >= int'(m_base[k]) &&
             int'(va) < int'(m_base[k]) + (1 << int'(m_lg[k])))
            return k;
      end
      return -1;
   endfunction

   task automatic m_remove(int k);
      for (int j = k; j < m_cnt - 1; j++) begin
         m_base[j] = m_base[j+1]; m_lg[j] = m_lg[j+1];
         m_pa[j] = m_pa[j+1]; m_glob[j] = m_glob[j+1];
      end
      m_cnt--;
   endtask

   task automatic m_insert_front(logic [VA_W-1:0] b, logic [LG_W-1:0] l,
                                 logic [PA_W-1:0] p, logic g);
      if (m_cnt == N) m_cnt--;
      for (int j = m_cnt; j > 0; j--) begin
         m_base[j] = m_base[j-1]; m_lg[j] = m_lg[j-1];
         m_pa[j] = m_pa[j-1]; m_glob[j] = m_glob[j-1];
      end
      m_base[0] = b; m_lg[0] = l; m_pa[0] = p; m_glob[0] = g;
      m_cnt++;
   endtask

   task automatic step(input logic [2:0] op, input logic [VA_W-1:0] cva,
                       input logic [LG_W-1:0] clg, input logic [PA_W-1:0] cpa,
                       input logic cg, input logic [VA_W-1:0] lva,
                       input logic touch, input string tag);
      int k;
      logic            e_hit;
      logic [PA_W-1:0] e_pa;
      logic [LG_W-1:0] e_lg;
      logic            e_g;
      @(negedge clk);
      cmd_op = op; cmd_va = cva; cmd_size = clg; cmd_pa = cpa; cmd_global = cg;
      lk_va = lva; lk_touch = touch;
      #1;
      k = m_find(lva);
      e_hit = (k >= 0);
      e_pa = '0; e_lg = '0; e_g = 1'b0;
      if (k >= 0) begin
         e_pa = m_pa[k] | PA_W'(int'(lva) % (1 << int'(m_lg[k])));
         e_lg = m_lg[k];
         e_g  = m_glob[k];
      end
      vectors++;
      if (lk_hit !== e_hit || lk_pa !== e_pa || lk_size !== e_lg || lk_global !== e_g) begin
         miscompares++;
         $display("FAIL %s va=%h: got hit=%b pa=%h sz=%0d g=%b, expected hit=%b pa=%h sz=%0d g=%b",
                  tag, lva, lk_hit, lk_pa, lk_size, lk_global, e_hit, e_pa, e_lg, e_g);
      end
      @(posedge clk);
      case (op)
         3'd1: m_insert_front(cva, clg, cpa, cg);
         3'd2: m_cnt = 0;
         3'd3: begin
            for (int j = m_cnt - 1; j >= 0; j--) if (!m_glob[j]) m_remove(j);
         end
         3'd4: begin
            int d;
            d = m_find(cva);
            if (d >= 0) m_remove(d);
         end
         default: begin
            if (touch && k >= 0) begin
               logic [VA_W-1:0] b; logic [LG_W-1:0] l; logic [PA_W-1:0] p; logic g;
               b = m_base[k]; l = m_lg[k]; p = m_pa[k]; g = m_glob[k];
               m_remove(k);
               m_insert_front(b, l, p, g);
            end
         end
      endcase
   endtask

   task automatic look(logic [VA_W-1:0] va, logic touch, string tag);
      step(3'd0, '0, '0, '0, 1'b0, va, touch, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      look(16'h0100, 1'b0, "R1 reset miss");
      look(16'h0000, 1'b1, "R1 reset miss");
      // R12: the fill is not visible in its own cycle
      step(3'd1, 16'h0100, 4'd4, 20'h05000, 1'b0, 16'h0100, 1'b0, "R12 same-cycle fill");
      look(16'h0100, 1'b0, "R2 first byte");
      look(16'h010F, 1'b0, "R3 offset or");
      look(16'h0110, 1'b0, "R2 past end");
      look(16'h00FF, 1'b0, "R2 below start");
      step(3'd1, 16'h0200, 4'd5, 20'h06000, 1'b1, 16'h0200, 1'b0, "R4 fill");
      step(3'd1, 16'h0300, 4'd3, 20'h07000, 1'b0, 16'h0300, 1'b0, "R4 fill");
      step(3'd1, 16'h0400, 4'd6, 20'h08000, 1'b0, 16'h0400, 1'b0, "R4 fill");
      look(16'h0100, 1'b0, "R4 all resident");
      look(16'h021F, 1'b0, "R4 all resident");
      look(16'h0307, 1'b0, "R4 all resident");
      look(16'h043F, 1'b0, "R4 all resident");
      look(16'h0104, 1'b1, "R7 touch");
      step(3'd1, 16'h0500, 4'd4, 20'h09000, 1'b0, 16'h0500, 1'b0, "R5 evict");
      look(16'h0200, 1'b0, "R5 lru evicted");
      look(16'h0100, 1'b0, "R5 touched kept");
      look(16'h0300, 1'b0, "R7 no-touch lookup");
      step(3'd1, 16'h0600, 4'd4, 20'h0A000, 1'b0, 16'h0600, 1'b0, "R7 fill");
      look(16'h0300, 1'b0, "R7 order unchanged");
      step(3'd1, 16'h0700, 4'd4, 20'h0B000, 1'b0, 16'h0400, 1'b1, "R12 touch with command");
      look(16'h0400, 1'b0, "R12 touch suppressed");
      look(16'h0100, 1'b1, "R7 touch");
      step(3'd1, 16'h0100, 4'd8, 20'h0C000, 1'b1, 16'h0105, 1'b0, "R6 fill overlap");
      look(16'h0105, 1'b0, "R8 newest overlap wins");
      step(3'd4, 16'h0105, 4'd0, 20'h0, 1'b0, 16'h0105, 1'b0, "R11 drop");
      look(16'h0105, 1'b0, "R11 older overlap remains");
      look(16'h0700, 1'b0, "R11 others kept");
      step(3'd1, 16'h0200, 4'd5, 20'h06000, 1'b1, 16'h0200, 1'b0, "R6 fill");
      step(3'd3, 16'h0000, 4'd0, 20'h0, 1'b0, 16'h0100, 1'b0, "R10 flush local");
      look(16'h0200, 1'b0, "R10 global kept");
      look(16'h0100, 1'b0, "R10 local freed");
      step(3'd2, 16'h0000, 4'd0, 20'h0, 1'b0, 16'h0200, 1'b0, "R9 flush all");
      look(16'h0200, 1'b0, "R9 freed");

      for (int n = 0; n < 6000; n++) begin
         int r;
         logic [2:0]      op;
         logic [LG_W-1:0] lg;
         logic [VA_W-1:0] b, la;
         r  = int'($urandom % 32);
         lg = LG_W'($urandom % 7);
         b  = VA_W'($urandom & 32'h0FFF) & ~VA_W'((1 << int'(lg)) - 1);
         if (r < 12)      op = 3'd0;
         else if (r < 22) op = 3'd1;
         else if (r < 26) op = 3'd4;
         else if (r == 26) op = 3'd3;
         else if (r == 27) op = 3'd2;
         else             op = 3'(5 + ($urandom % 3));
         if (m_cnt > 0 && ($urandom % 2) == 0) begin
            int k;
            k  = int'($urandom % m_cnt);
            la = m_base[k] + VA_W'($urandom % (1 << (int'(m_lg[k]) + 1)));
         end else begin
            la = VA_W'($urandom & 32'h0FFF);
         end
         if (op == 3'd4 && ($urandom % 2) == 0) b = la;
         step(op, b, lg, PA_W'($urandom) & ~PA_W'(32'h3F), 1'($urandom),
              la, 1'($urandom), "R8 random mix");
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule